// File: doc/BRIEF.md
# Oversampled Manchester line receiver with word framing

This block takes a Manchester-coded serial line sampled by a local clock that runs at about eight times the bit rate. It recovers each data bit together with a one-cycle strobe. It then frames 16-bit words out of that bit stream and presents each one on a parallel output with a one-cycle valid pulse. A word is sent as a run of zero bits, then a single one bit (the start marker), then the data bits with the most significant bit first.

Bit recovery is driven by edges rather than by a fixed sample phase. Each accepted mid-cell transition re-times the decoder. Transitions that arrive too soon after it are treated as cell-boundary transitions and ignored. Because of this, the transmitter and receiver clocks may differ noticeably. Framing passes the start marker down the shift chain. When the marker arrives at the far end, the chain holds a complete word and the output register is loaded. A frame that loses lock part-way through produces no output.

Top module: `manch_rx`

## Requirements
- R1: Line coding: a 1 is a high first half-cell followed by a low second half, and a 0 is low then high. `bit_o` carries the decoded value and is valid in the cycle in which `strobe_o` is high. `strobe_o` is high for single cycles only.
- R2: When not locked, the decoder takes the first low-to-high transition as the middle of a zero cell, locks, and issues a strobe with `bit_o` = 0.
- R3: When locked, transitions seen within BLANK = 3·OSR/4 samples (6) of the last accepted mid-cell transition are ignored. Words decode correctly at bit periods of 7, 8, 9 and 10 samples, including unequal half-cells.
- R4: If no transition is accepted within TMO = 3·OSR/2 samples (12), lock is dropped and the word being assembled is discarded with no valid pulse. A later frame with a full preamble is received normally.
- R5: A one bit counts as a start marker only if at least MIN_ZEROS (18) consecutive zero bits come before it, counted from lock acquisition or from the end of the previous word. With 17 zeros no word is produced.
- R6: The WORD_W (16) bits that follow the start marker form the word. The first bit received lands in `word_o[15]` and the last in `word_o[0]`.
- R7: `word_valid_o` is high for exactly one cycle per framed word. `word_o` changes only in that cycle and holds its value otherwise.
- R8: Two frames separated by exactly MIN_ZEROS zero bits, with no idle gap, both produce words.
- R9: After reset, `bit_o`, `strobe_o`, `word_o` and `word_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, about OSR times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Raw Manchester line, asynchronous to clk_i |
| bit_o | output | 1 | Recovered data bit |
| strobe_o | output | 1 | One-cycle marker for a valid recovered bit |
| word_o | output | WORD_W | Last framed word, first received bit in the MSB |
| word_valid_o | output | 1 | One-cycle pulse when word_o is loaded |

## Verification
The bench uses the default parameters: OSR = 8, WORD_W = 16, MIN_ZEROS = 18 and two synchronizer stages. These give a blanking window of 6 samples and a timeout of 12. Bit periods of 7 to 10 samples, including unequal half-cells, therefore fall inside the tolerated range. The preamble boundary can be tested at exactly 17 and 18 zeros, and a stalled frame can be made to exceed the timeout within a few dozen cycles.

// File: rtl/manch_pkg.sv
package manch_pkg;
  localparam int DEF_OSR       = 8;
  localparam int DEF_WORD_W    = 16;
  localparam int DEF_MIN_ZEROS = 18;

  // earliest sample at which a mid-cell edge may follow the previous one
  function automatic int blank_len(input int osr);
    return (osr * 3) / 4;
  endfunction

  // samples without an accepted edge before lock is dropped
  function automatic int tmo_len(input int osr);
    return (osr * 3) / 2;
  endfunction
endpackage

// File: rtl/manch_sync.sv
module manch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/manch_edge_dec.sv
module manch_edge_dec #(
  parameter int OSR = manch_pkg::DEF_OSR
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic bit_o,
  output logic strobe_o,
  output logic lock_o
);
  localparam int BLANK = manch_pkg::blank_len(OSR);
  localparam int TMO   = manch_pkg::tmo_len(OSR);
  localparam int CW    = $clog2(TMO + 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          lock_q, strobe_q, bit_q;

  logic edge_w, accept_w, expire_w;
  assign edge_w   = din_i ^ prev_q;
  // unlocked: a rising edge is taken as mid-cell of a preamble zero
  assign accept_w = lock_q ? (edge_w && (cnt_q >= CW'(BLANK - 1)))
                           : (din_i && !prev_q);
  assign expire_w = lock_q && !accept_w && (cnt_q >= CW'(TMO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      cnt_q    <= '0;
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      prev_q   <= din_i;
      strobe_q <= accept_w;
      if (accept_w) begin
        bit_q  <= prev_q;  // level before the mid-cell edge is the data
        lock_q <= 1'b1;
        cnt_q  <= '0;
      end else if (expire_w) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end else if (lock_q) begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign bit_o    = bit_q;
  assign strobe_o = strobe_q;
  assign lock_o   = lock_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |=> !strobe_q);  // R1
  AST_STROBE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> lock_q);  // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TMO - 1));  // R4
endmodule

// File: rtl/manch_deser.sv
module manch_deser #(
  parameter int WORD_W    = manch_pkg::DEF_WORD_W,
  parameter int MIN_ZEROS = manch_pkg::DEF_MIN_ZEROS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              strobe_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int ZW = $clog2(MIN_ZEROS + 1);

  logic [WORD_W-1:0] chain_q, word_q;
  logic              hunt_q, valid_q;
  logic [ZW-1:0]     zcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      word_q  <= '0;
      hunt_q  <= 1'b1;
      valid_q <= 1'b0;
      zcnt_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!lock_i) begin
        chain_q <= '0;
        hunt_q  <= 1'b1;
        zcnt_q  <= '0;
      end else if (strobe_i) begin
        if (hunt_q) begin
          if (bit_i) begin
            if (zcnt_q >= ZW'(MIN_ZEROS)) begin
              hunt_q  <= 1'b0;
              chain_q <= {{(WORD_W-1){1'b0}}, 1'b1};  // marker enters
            end
            zcnt_q <= '0;
          end else if (zcnt_q < ZW'(MIN_ZEROS)) begin
            zcnt_q <= zcnt_q + ZW'(1);
          end
        end else if (chain_q[WORD_W-1]) begin
          // marker leaves the far end: chain holds a whole word
          word_q  <= {chain_q[WORD_W-2:0], bit_i};
          valid_q <= 1'b1;
          chain_q <= '0;
          hunt_q  <= 1'b1;
          zcnt_q  <= '0;
        end else begin
          chain_q <= {chain_q[WORD_W-2:0], bit_i};
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);  // R7
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(word_q));  // R7
  AST_UNLOCK_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !valid_q);  // R4
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int OSR         = manch_pkg::DEF_OSR,
  parameter int WORD_W      = manch_pkg::DEF_WORD_W,
  parameter int MIN_ZEROS   = manch_pkg::DEF_MIN_ZEROS,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              bit_o,
  output logic              strobe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic line_s, dec_bit, dec_stb, dec_lock;

  manch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  manch_edge_dec #(.OSR(OSR)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .din_i   (line_s),
    .bit_o   (dec_bit),
    .strobe_o(dec_stb),
    .lock_o  (dec_lock)
  );

  manch_deser #(.WORD_W(WORD_W), .MIN_ZEROS(MIN_ZEROS)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (dec_lock),
    .strobe_i(dec_stb),
    .bit_i   (dec_bit),
    .word_o  (word_o),
    .valid_o (word_valid_o)
  );

  assign bit_o    = dec_bit;
  assign strobe_o = dec_stb;

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!dec_stb && !word_valid_o);  // R9
    end
  end
endmodule

// File: tb/manch_rx_tb_top.sv
module manch_rx_tb_top;
  localparam int WORD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_w, stb_w, valid_w;
  logic [WORD_W-1:0] word_w;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  manch_rx dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line),
    .bit_o       (bit_w),
    .strobe_o    (stb_w),
    .word_o      (word_w),
    .word_valid_o(valid_w)
  );

  // monitors sample away from the active edge
  int          vhigh = 0;
  logic [15:0] last_word = '0;
  logic [63:0] hist = '0;
  always @(negedge clk) begin
    if (valid_w) begin
      vhigh     <= vhigh + 1;
      last_word <= word_w;
    end
    if (stb_w) hist <= {hist[62:0], bit_w};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int h1, input int h2);
    line = b;
    repeat (h1) @(negedge clk);
    line = ~b;
    repeat (h2) @(negedge clk);
  endtask

  task automatic send_frame(input int pre, input logic [15:0] w, input int h1,
                            input int h2, input int tail);
    for (int i = 0; i < pre; i++) send_bit(1'b0, h1, h2);
    send_bit(1'b1, h1, h2);
    for (int i = 15; i >= 0; i--) send_bit(w[i], h1, h2);
    for (int i = 0; i < tail; i++) send_bit(1'b0, h1, h2);
  endtask

  task automatic idle();
    repeat (40) @(negedge clk);
  endtask

  // {word, first half, second half}
  localparam logic [31:0] VECS [0:5] = '{
    32'hA5C3_0404, 32'h8001_0404, 32'h0000_0304,
    32'hFFFF_0405, 32'h1234_0505, 32'h7FFE_0403
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    check(word_w == '0, "R9 word", word_w, 0);
    check(!valid_w, "R9 valid", valid_w, 0);
    check(!stb_w && !bit_w, "R9 strobe/bit", {stb_w, bit_w}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      logic [15:0] w;
      w = VECS[k][31:16];
      v0 = vhigh;
      send_frame(20, w, int'(VECS[k][15:8]), int'(VECS[k][7:0]), 4);
      repeat (6) @(negedge clk);
      check(vhigh - v0 == 1, "R7 R3 one valid cycle", vhigh - v0, 1);
      check(last_word == w, "R6 R3 word value", last_word, w);
      check(hist[20:0] == {1'b1, w, 4'b0000}, "R1 R2 strobed bits",
            hist[20:0], {1'b1, w, 4'b0000});
      idle();
    end

    // R6 explicit: first bit received is the MSB
    send_frame(20, 16'h8000, 4, 4, 4);
    repeat (6) @(negedge clk);
    check(last_word == 16'h8000, "R6 msb first", last_word, 16'h8000);
    idle();

    // R5: 17 zeros is too short
    v0 = vhigh;
    send_frame(17, 16'hFFFF, 4, 4, 4);
    repeat (6) @(negedge clk);
    check(vhigh == v0, "R5 short preamble rejected", vhigh - v0, 0);
    idle();

    // R5: exactly 18 zeros accepted
    v0 = vhigh;
    send_frame(18, 16'h3C3C, 4, 4, 4);
    repeat (6) @(negedge clk);
    check(vhigh - v0 == 1 && last_word == 16'h3C3C, "R5 18 zeros accepted",
          last_word, 16'h3C3C);
    idle();

    // R4: stall mid-frame, then recover
    v0 = vhigh;
    for (int i = 0; i < 20; i++) send_bit(1'b0, 4, 4);
    send_bit(1'b1, 4, 4);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 4, 4);
    idle();
    check(vhigh == v0, "R4 stalled frame dropped", vhigh - v0, 0);
    send_frame(20, 16'h5A5A, 4, 4, 4);
    repeat (6) @(negedge clk);
    check(vhigh - v0 == 1 && last_word == 16'h5A5A, "R4 recovery", last_word,
          16'h5A5A);
    idle();

    // R8: back-to-back frames, 18 zeros between
    v0 = vhigh;
    send_frame(20, 16'h1111, 4, 4, 0);
    send_frame(18, 16'h2222, 4, 4, 4);
    repeat (6) @(negedge clk);
    check(vhigh - v0 == 2, "R8 two words", vhigh - v0, 2);
    check(last_word == 16'h2222, "R8 second word", last_word, 16'h2222);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule